// File: doc/BRIEF.md
# Receive Character Queue with Error Status

This block is the receive side of a UART with the serial deserializer left out. Characters arrive from a valid/char/flags input. Each character is stored in a first-in first-out queue together with its framing, parity and break indications. Software reaches the block through a small register interface with two addresses.

Address 0 is the data port. A read of it removes the oldest character from the queue and returns the character and its error flags. Address 1 gives the error status when read and acts as an error clear when written.

The framing, parity and break status describes the character most recently removed through the data port. It does not describe the character at the front of the queue. Overrun is recorded in the cycle after a character arrives while the queue is full. The incoming character is dropped and the stored characters are kept. Read data comes back one cycle after the read strobe.

Top module: `rx_err_fifo`

## Requirements
- R1: After reset the queue is empty (`rx_empty`=1, `rx_full`=0), the status register reads 0 and `bus_rdata` is 0 when no read is pending.
- R2: Data-port reads return characters in arrival order, one cycle after the strobe. The character is in [7:0], framing error in bit 8, parity error in bit 9, break in bit 10, and the current overrun flag in bit 11. Bits 31:12 are 0.
- R3: A status read returns framing error at bit 0, parity at bit 1, break at bit 2 and overrun at bit 3, with bits 31:4 reading 0. Bits 2:0 reflect the entry removed by the latest data-port read, including a read in the previous cycle. Later arrivals do not change them.
- R4: A data-port read while the queue is empty returns 0 in bits [10:0] with the overrun flag in bit 11. It removes nothing and leaves status bits 2:0 unchanged.
- R5: A character that arrives while the queue holds DEPTH entries sets the overrun flag, which is visible from the next cycle. The character is discarded and all stored entries read back intact.
- R6: The overrun flag stays set after the queue is drained, until a write to address 1.
- R7: A write of any value to address 1 clears all four status bits. If an overrun occurs in the same cycle, overrun ends up set and the other three bits end up clear.
- R8: Writes to address 0 have no effect. A write to address 1 can never set a status bit.
- R9: `rx_full` is 1 exactly when DEPTH entries are stored, and `rx_empty` is 1 exactly when none are.
- R10: An arrival and a data-port read in the same cycle, with the queue neither empty nor full, keep the entry count unchanged and preserve order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | One-cycle strobe: a character is complete |
| rx_char | input | 8 | Received character |
| rx_flags | input | 3 | Bit 0 framing, bit 1 parity, bit 2 break |
| bus_addr | input | 1 | 0 = data port, 1 = status / clear |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data (value ignored) |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| rx_empty | output | 1 | Queue holds no entries |
| rx_full | output | 1 | Queue holds DEPTH entries |

## Verification
On every cycle, the assertions check the following:
- The entry count never exceeds DEPTH and never changes on a blocked arrival.
- Removal never happens from an empty queue.
- An overrun event always leaves the flag set.
- The flag holds until a clear.
- A clear without a coinciding overrun zeroes the status.

Other behaviours can only be shown by the bench's scenarios:
- Order and intactness of the stored characters after an overrun.
- Forwarding of the just-removed entry's flags into a status read in the next cycle.
- Read-data layout.
- The no-effect cases of empty reads and data-port writes.

// File: rtl/rx_err_pkg.sv
package rx_err_pkg;
  localparam int FLAG_W = 3;
  localparam int FE_BIT = 0;
  localparam int PE_BIT = 1;
  localparam int BE_BIT = 2;
  localparam int OE_BIT = 3;

  typedef enum logic [1:0] {
    RSEL_NONE  = 2'd0,
    RSEL_DATA  = 2'd1,
    RSEL_EMPTY = 2'd2,
    RSEL_STAT  = 2'd3
  } rsel_e;
endpackage

// File: rtl/rx_char_store.sv
module rx_char_store #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic             empty,
  output logic             full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;
  logic             wr_en;

  assign empty = (count == '0);
  assign full  = (count == FULL_CNT);
  assign wr_en = push && !full;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (pop) dout <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (wr_en) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (pop)   rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      case ({wr_en, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    count <= FULL_CNT); // R9
  AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty); // R4
  AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    (full && push && !pop) |=> (full && $stable(wr_ptr))); // R5
  AST_SAME_LEVEL: assert property (@(posedge clk) disable iff (rst)
    (push && pop && !full) |=> $stable(count)); // R10
endmodule

// File: rtl/rx_err_status.sv
module rx_err_status
  import rx_err_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              pop_d,
  input  logic [FLAG_W-1:0] pop_flags,
  input  logic              ovr_evt,
  input  logic              clr,
  output logic              ovr,
  output logic [3:0]        stat_view
);
  logic [FLAG_W-1:0] flags;

  always_ff @(posedge clk) begin
    if (rst) begin
      flags <= '0;
      ovr   <= 1'b0;
    end else begin
      if (clr)        flags <= '0;
      else if (pop_d) flags <= pop_flags;
      if (ovr_evt)    ovr <= 1'b1;
      else if (clr)   ovr <= 1'b0;
    end
  end

  always_comb begin
    stat_view         = '0;
    stat_view[OE_BIT] = ovr;
    stat_view[BE_BIT:FE_BIT] = pop_d ? pop_flags : flags;
  end

  AST_OVR_SETS: assert property (@(posedge clk) disable iff (rst)
    ovr_evt |=> ovr); // R5
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (rst)
    (ovr && !clr) |=> ovr); // R6
  AST_CLR_ALL: assert property (@(posedge clk) disable iff (rst)
    (clr && !ovr_evt) |=> (!ovr && flags == '0)); // R7
  AST_POP_LOADS: assert property (@(posedge clk) disable iff (rst)
    (pop_d && !clr) |=> (flags == $past(pop_flags))); // R3
endmodule

// File: rtl/rx_err_fifo.sv
module rx_err_fifo
  import rx_err_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  parameter int BUS_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_valid,
  input  logic [DW-1:0]    rx_char,
  input  logic [2:0]       rx_flags,
  input  logic             bus_addr,
  input  logic             bus_rd,
  input  logic             bus_wr,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata,
  output logic             rx_empty,
  output logic             rx_full
);
  localparam int ENT_W = DW + FLAG_W;

  logic [ENT_W-1:0] ent_q;
  logic             pop, pop_d, ovr_evt, clr, stat_rd, ovr;
  logic [3:0]       stat_view, stat_snap;
  logic             ovr_snap;
  rsel_e            sel_q;
  logic             unused_wdata;

  assign unused_wdata = ^bus_wdata;
  assign pop     = bus_rd && !bus_addr && !rx_empty;
  assign ovr_evt = rx_valid && rx_full;
  assign clr     = bus_wr && bus_addr;
  assign stat_rd = bus_rd && bus_addr;

  rx_char_store #(.DEPTH(DEPTH), .WIDTH(ENT_W)) u_store (
    .clk   (clk),
    .rst   (rst),
    .push  (rx_valid),
    .din   ({rx_flags, rx_char}),
    .pop   (pop),
    .dout  (ent_q),
    .empty (rx_empty),
    .full  (rx_full)
  );

  rx_err_status u_status (
    .clk       (clk),
    .rst       (rst),
    .pop_d     (pop_d),
    .pop_flags (ent_q[DW +: FLAG_W]),
    .ovr_evt   (ovr_evt),
    .clr       (clr),
    .ovr       (ovr),
    .stat_view (stat_view)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pop_d     <= 1'b0;
      sel_q     <= RSEL_NONE;
      ovr_snap  <= 1'b0;
      stat_snap <= '0;
    end else begin
      pop_d <= pop;
      if (bus_rd) ovr_snap <= ovr;
      if (stat_rd) stat_snap <= stat_view;
      if (stat_rd)                sel_q <= RSEL_STAT;
      else if (pop)               sel_q <= RSEL_DATA;
      else if (bus_rd)            sel_q <= RSEL_EMPTY;
      else                        sel_q <= RSEL_NONE;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (sel_q)
      RSEL_DATA: begin
        bus_rdata[ENT_W-1:0] = ent_q;
        bus_rdata[ENT_W]     = ovr_snap;
      end
      RSEL_EMPTY: bus_rdata[ENT_W] = ovr_snap;
      RSEL_STAT:  bus_rdata[3:0]   = stat_snap;
      default:    bus_rdata = '0;
    endcase
  end

  AST_EMPTY_FULL_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(rx_empty && rx_full)); // R9
endmodule

// File: tb/rx_err_fifo_bench.sv
`timescale 1ns/1ps
module rx_err_fifo_bench;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst;
  logic        rx_valid;
  logic [7:0]  rx_char;
  logic [2:0]  rx_flags;
  logic        bus_addr, bus_rd, bus_wr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        rx_empty, rx_full;

  int tests = 0;
  int fails = 0;

  logic [10:0] mq [DEPTH];
  int   m_head = 0, m_cnt = 0;
  logic m_ovr = 1'b0;
  logic [2:0] m_flags = 3'b0;

  always #2.5 clk = ~clk;

  rx_err_fifo u_rx_err_fifo (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_char(rx_char),
    .rx_flags(rx_flags), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_empty(rx_empty), .rx_full(rx_full)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic void m_push(input logic [7:0] d, input logic [2:0] f);
    if (m_cnt == DEPTH) m_ovr = 1'b1;
    else begin
      mq[(m_head + m_cnt) % DEPTH] = {f, d};
      m_cnt++;
    end
  endfunction

  task automatic push(input logic [7:0] d, input logic [2:0] f);
    @(negedge clk);
    rx_valid = 1'b1; rx_char = d; rx_flags = f;
    @(negedge clk);
    rx_valid = 1'b0;
    m_push(d, f);
  endtask

  task automatic rd_data(input string req);
    logic [31:0] exp;
    @(negedge clk);
    bus_addr = 1'b0; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    if (m_cnt > 0) begin
      exp = {20'b0, m_ovr, mq[m_head]};
      m_flags = mq[m_head][10:8];
      m_head = (m_head + 1) % DEPTH;
      m_cnt--;
    end else exp = {20'b0, m_ovr, 11'b0};
    check(req, bus_rdata, exp);
  endtask

  task automatic rd_stat(input string req);
    @(negedge clk);
    bus_addr = 1'b1; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    check(req, bus_rdata, {28'b0, m_ovr, m_flags});
  endtask

  task automatic wr(input logic a, input logic [31:0] v);
    @(negedge clk);
    bus_addr = a; bus_wr = 1'b1; bus_wdata = v;
    @(negedge clk);
    bus_wr = 1'b0;
    if (a) begin m_ovr = 1'b0; m_flags = 3'b0; end
  endtask

  task automatic push_pop(input logic [7:0] d, input logic [2:0] f, input string req);
    logic [31:0] exp;
    @(negedge clk);
    rx_valid = 1'b1; rx_char = d; rx_flags = f; bus_addr = 1'b0; bus_rd = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0; bus_rd = 1'b0;
    exp = {20'b0, m_ovr, mq[m_head]};
    m_flags = mq[m_head][10:8];
    m_head = (m_head + 1) % DEPTH;
    m_cnt--;
    m_push(d, f);
    check(req, bus_rdata, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst = 1'b1; rx_valid = 1'b0; rx_char = '0; rx_flags = '0;
    bus_addr = 1'b0; bus_rd = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 empty", {31'b0, rx_empty}, 32'd1);
    check("R1 full", {31'b0, rx_full}, 32'd0);
    check("R1 rdata idle", bus_rdata, 32'd0);
    rd_stat("R1 status");

    // R3 all flag combinations, one at a time
    for (int f = 0; f < 8; f++) begin
      push(8'(f * 29 + 1), 3'(f));
      rd_data("R2 single");
      rd_stat("R3 flags");
    end

    // R3 later arrival does not disturb status
    push(8'h51, 3'b101);
    rd_data("R2 pop");
    push(8'h52, 3'b010);
    rd_stat("R3 after arrival");
    rd_data("R2 pop2");

    // R9 fill to full
    for (int i = 0; i < DEPTH; i++) begin
      check("R9 not full while filling", {31'b0, rx_full}, 32'd0);
      push(8'(i * 17 + 3), 3'(i % 8));
    end
    check("R9 full", {31'b0, rx_full}, 32'd1);
    // R5 overrun
    push(8'hAA, 3'b111);
    rd_stat("R5 overrun set");
    check("R9 still full", {31'b0, rx_full}, 32'd1);
    for (int i = 0; i < DEPTH; i++) begin
      rd_data("R5 contents intact");
      rd_stat("R3 forwarded flags");
    end
    check("R9 empty after drain", {31'b0, rx_empty}, 32'd1);
    rd_stat("R6 overrun sticky");
    rd_data("R4 empty read");
    rd_stat("R4 status unchanged");

    // R8 writes with no effect
    wr(1'b0, 32'hFFFF_FFFF);
    rd_stat("R8 data write ignored");
    check("R8 empty kept", {31'b0, rx_empty}, 32'd1);
    // R7 clear with any value
    wr(1'b1, 32'h0);
    rd_stat("R7 clear");
    wr(1'b1, 32'hF);
    rd_stat("R8 clear cannot set");

    // R10 push and pop together
    push(8'h11, 3'b001);
    push(8'h22, 3'b010);
    for (int i = 0; i < 6; i++) push_pop(8'(8'h30 + i), 3'(i), "R10 concurrent");
    rd_data("R10 order");
    rd_data("R10 order");
    check("R10 empty", {31'b0, rx_empty}, 32'd1);

    // R7 clear coinciding with overrun
    for (int i = 0; i < DEPTH; i++) push(8'(255 - i), 3'((i + 3) % 8));
    rd_data("R2 pop before refill");
    push(8'h77, 3'b100);
    @(negedge clk);
    rx_valid = 1'b1; rx_char = 8'h99; rx_flags = 3'b011;
    bus_addr = 1'b1; bus_wr = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0; bus_wr = 1'b0;
    m_flags = 3'b0; m_ovr = 1'b1;
    rd_stat("R7 set wins");
    for (int i = 0; i < DEPTH; i++) rd_data("R5 drain after coincident");
    wr(1'b1, 32'h1234);
    rd_stat("R6 cleared after drain");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule